// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a programmable interval timer. It takes a binary initial count and a three-bit operating mode. It counts qualified ticks of an input tick strobe from the moment the count is loaded, and it drives one output whose waveform depends on the mode. A set of these channels, each with its own tick strobe, gate and load port, forms a complete interval timer.

Loading a count and a mode restarts the tick measurement at zero. Every output rule is measured against the number of ticks that have passed since that load or since the last restart. The gate input restarts the measurement on a rising edge, but only in the modes that respond to the gate. A programmed count of zero stands for the full range of the counter. The channel also reports how many ticks remain in the current period. Only binary counting is supported.

Top module: `interval_chan`

## Requirements
- R1: A loaded count of 0 is treated as a period of 2^CNT_W ticks. The remaining-count output then reads 0 right after the load and 2^CNT_W-d at elapsed tick d.
- R2: Mode 0 (mode_i = 3'd0): out_o is low while elapsed ticks d < period, and high from d = period onward.
- R3: Mode 1 (3'd1): out_o is high while d < period, and low from then on.
- R4: Mode 2 (3'd2): out_o is high exactly when d is a nonzero multiple of the period, and low otherwise.
- R5: Mode 3 (3'd3): out_o is high when (d mod period) < (period+1)/2, and low otherwise.
- R6: Modes 4 and 5 (3'd4, 3'd5): out_o is high only while d equals the period.
- R7: Mode values 3'd6 and 3'd7 produce the same output as mode 0.
- R8: In modes 1, 2, 3 and 5, a gate_i rising edge seen at a clock edge sets d to 0 at that edge.
- R9: In modes 0 and 4, a gate_i rising edge has no effect, and d keeps advancing.
- R10: load_i at a clock edge captures count_i and mode_i and sets d to 0. On the next cycle cur_o equals count_i. load_i has priority over a gate restart and over a tick.
- R11: cur_o equals (period - (d mod period)), truncated to CNT_W bits.
- R12: d advances by one only at clock edges where tick_i is high. With tick_i low and no load or restart, out_o and cur_o hold their values.
- R13: After reset, the mode is 0, the period is 2^CNT_W and d is 0, so out_o is low and cur_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe; one tick per cycle when high |
| gate_i | input | 1 | Gate level; its rising edge restarts counting in gated modes |
| load_i | input | 1 | Load strobe for count_i and mode_i |
| count_i | input | CNT_W | Initial count, 0 meaning 2^CNT_W |
| mode_i | input | 3 | Operating mode |
| out_o | output | 1 | Channel output |
| cur_o | output | CNT_W | Ticks remaining in the current period |

## Verification
The hardest states to reach are the points where the tick count crosses the period: the last tick before it, the tick equal to it, and the ticks past it. A gate edge landing partway into a period is equally hard to place. The bench builds the channel with a 4-bit counter so that every count, including 0, and every mode value can be swept. Each sweep runs for more than two periods, which passes each of these crossings. A gate edge is then placed mid-period in every mode, and in a separate run the tick strobe is held off for several cycles.

// File: rtl/ichan_pkg.sv
package ichan_pkg;

  typedef enum logic [2:0] {
    M_ONESHOT_LOW  = 3'd0,
    M_GATED_HIGH   = 3'd1,
    M_PULSE_RATE   = 3'd2,
    M_SQUARE       = 3'd3,
    M_SOFT_STROBE  = 3'd4,
    M_HARD_STROBE  = 3'd5
  } mode_e;

  function automatic logic gate_restarts(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
  endfunction

endpackage

// File: rtl/ichan_edge.sv
module ichan_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ichan_count.sv
module ichan_count #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PER_W = CNT_W + 1,
  localparam int unsigned ELA_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic [ELA_W-1:0] elapsed_o,
  output logic [PER_W-1:0] phase_o
);
  logic [ELA_W-1:0] elapsed_q;
  logic [PER_W-1:0] phase_q;
  logic [ELA_W-1:0] period_ext;

  assign period_ext = ELA_W'(period_i);

  // elapsed saturates at period+1: enough to tell below, equal and beyond
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      phase_q   <= '0;
    end else if (clear_i) begin
      elapsed_q <= '0;
      phase_q   <= '0;
    end else if (tick_i) begin
      if (elapsed_q <= period_ext) elapsed_q <= elapsed_q + 1'b1;
      if (phase_q == period_i - 1'b1) phase_q <= '0;
      else                            phase_q <= phase_q + 1'b1;
    end
  end

  assign elapsed_o = elapsed_q;
  assign phase_o   = phase_q;
endmodule

// File: rtl/ichan_wave.sv
module ichan_wave #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PER_W = CNT_W + 1,
  localparam int unsigned ELA_W = CNT_W + 2
) (
  input  logic [2:0]       mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [ELA_W-1:0] elapsed_i,
  input  logic [PER_W-1:0] phase_i,
  output logic             out_o
);
  logic [ELA_W-1:0] period_ext;
  logic [PER_W-1:0] half;

  assign period_ext = ELA_W'(period_i);
  assign half       = PER_W'((ELA_W'(period_i) + 1'b1) >> 1);

  always_comb begin
    unique case (mode_i)
      3'd1:       out_o = elapsed_i < period_ext;
      3'd2:       out_o = (phase_i == '0) && (elapsed_i != '0);
      3'd3:       out_o = phase_i < half;
      3'd4, 3'd5: out_o = elapsed_i == period_ext;
      default:    out_o = elapsed_i >= period_ext;
    endcase
  end
endmodule

// File: rtl/interval_chan.sv
module interval_chan #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PER_W = CNT_W + 1,
  localparam int unsigned ELA_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       mode_i,
  output logic             out_o,
  output logic [CNT_W-1:0] cur_o
);
  import ichan_pkg::*;

  logic [PER_W-1:0] period_q;
  logic [2:0]       mode_q;
  logic             gate_rise;
  logic             clear;
  logic [ELA_W-1:0] elapsed;
  logic [PER_W-1:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PER_W'(1) << CNT_W;
      mode_q   <= 3'd0;
    end else if (load_i) begin
      period_q <= (count_i == '0) ? (PER_W'(1) << CNT_W) : PER_W'(count_i);
      mode_q   <= mode_i;
    end
  end

  ichan_edge i_gate_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (gate_i),
    .rise_o (gate_rise)
  );

  assign clear = load_i | (gate_rise & gate_restarts(mode_q));

  ichan_count #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .tick_i    (tick_i),
    .period_i  (period_q),
    .elapsed_o (elapsed),
    .phase_o   (phase)
  );

  ichan_wave #(.CNT_W(CNT_W)) i_wave (
    .mode_i    (mode_q),
    .period_i  (period_q),
    .elapsed_i (elapsed),
    .phase_i   (phase),
    .out_o     (out_o)
  );

  assign cur_o = CNT_W'(period_q - phase);
endmodule

// File: rtl/ichan_check.sv
module ichan_check #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PER_W = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             gate_i,
  input logic             load_i,
  input logic [CNT_W-1:0] count_i,
  input logic [2:0]       mode_q,
  input logic [PER_W-1:0] period_q,
  input logic             out_o,
  input logic [CNT_W-1:0] cur_o
);
  logic gate_seen;
  logic rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_seen <= 1'b0;
    else         gate_seen <= gate_i;
  end
  assign rise = gate_i & ~gate_seen;

  assert_load_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_o == $past(count_i));

  assert_hold_no_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !gate_i) |=> ($stable(cur_o) && $stable(out_o)));

  assert_mode0_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0 && out_o && !load_i) |=> out_o);

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == 3'd4 || mode_q == 3'd5) && out_o && tick_i && !load_i) |=> !out_o);

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd2 && out_o && tick_i && !load_i && period_q > PER_W'(1)) |=> !out_o);

  assert_gate_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !load_i && (mode_q == 3'd1 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd5))
      |=> cur_o == CNT_W'($past(period_q)));
endmodule

bind interval_chan ichan_check #(.CNT_W(CNT_W)) i_check (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .gate_i   (gate_i),
  .load_i   (load_i),
  .count_i  (count_i),
  .mode_q   (mode_q),
  .period_q (period_q),
  .out_o    (out_o),
  .cur_o    (cur_o)
);

// File: tb/test_interval_chan.sv
module test_interval_chan;
  localparam int W = 4;
  localparam int FULL = 1 << W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic gate_i = 1'b0;
  logic load_i = 1'b0;
  logic [W-1:0] count_i = '0;
  logic [2:0] mode_i = '0;
  logic out_o;
  logic [W-1:0] cur_o;

  int checks = 0;
  int errors = 0;
  int d = 0;
  int per = FULL;
  int md = 0;

  always #2 clk_i = ~clk_i;

  interval_chan #(.CNT_W(W)) i_interval_chan (.*);

  function automatic bit exp_out(int m, int p, int e);
    case (m)
      1: return e < p;
      2: return (e % p == 0) && (e != 0);
      3: return (e % p) < ((p + 1) / 2);
      4, 5: return e == p;
      default: return e >= p;
    endcase
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6, 7: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag);
    logic eo;
    logic [W-1:0] ec;
    eo = exp_out(md, per, d);
    ec = W'(per - (d % per));
    checks++;
    if (out_o !== eo || cur_o !== ec) begin
      errors++;
      $display("FAIL %s mode=%0d per=%0d d=%0d: out=%b cur=%0d expected out=%b cur=%0d",
               tag, md, per, d, out_o, cur_o, eo, ec);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
    if (tick_i) d++;
  endtask

  task automatic load(int m, int c);
    load_i = 1'b1; mode_i = 3'(m); count_i = W'(c);
    @(posedge clk_i); #1;
    load_i = 1'b0;
    md = m; per = (c == 0) ? FULL : c; d = 0;
    check("R10");
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R13: reset state
    md = 0; per = FULL; d = 0;
    check("R13");
    rst_ni = 1'b1;

    // R1 R2..R7 R11: full sweep of modes and counts
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < FULL; c++) begin
        load(m, c);
        for (int k = 0; k < 2 * ((c == 0) ? FULL : c) + 3; k++) begin
          step();
          check(c == 0 ? "R1" : (k % 2 == 0 ? mode_tag(m) : "R11"));
        end
      end
    end

    // R8 R9: gate rising edge mid-period
    for (int m = 0; m < 8; m++) begin
      load(m, 6);
      repeat (4) begin step(); check(mode_tag(m)); end
      gate_i = 1'b1;
      @(posedge clk_i); #1;
      if (m == 1 || m == 2 || m == 3 || m == 5) d = 0; else d++;
      check((m == 1 || m == 2 || m == 3 || m == 5) ? "R8" : "R9");
      repeat (5) begin step(); check((m == 1 || m == 2 || m == 3 || m == 5) ? "R8" : "R9"); end
      gate_i = 1'b0;
      step(); check(mode_tag(m));
    end

    // R12: ticks withheld
    for (int m = 0; m < 6; m++) begin
      load(m, 5);
      repeat (3) begin step(); check(mode_tag(m)); end
      tick_i = 1'b0;
      repeat (4) begin step(); check("R12"); end
      tick_i = 1'b1;
      repeat (6) begin step(); check("R12"); end
    end

    // R10: load has priority over a simultaneous gate rise
    load(1, 7);
    repeat (3) step();
    gate_i = 1'b1;
    load(2, 3);
    repeat (4) begin step(); check("R10"); end
    gate_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule